// File: doc/BRIEF.md
# Card Host Register Block

This block is the register file and interrupt logic of a simple memory-card host peripheral attached to a 32-bit bus. It decodes a 4 KiB address window and keeps the control values that a separate command engine consumes: a transfer buffer address, a command code, a command argument, a block length and a block count. It also holds the four response words that the engine returns, and it presents the card-detect and write-protect pins as a readable register.

Software starts a command by writing the argument register and then the command register. That write produces a one-cycle start pulse toward the engine, along with the command code and the argument written most recently. When the engine finishes it raises completion flags. These flags are collected in a status register, masked by an enable register, and reduced to a single level interrupt line. Reads return data one cycle after the request. A read of an offset that has nothing to read returns zero and raises an error pulse.

Top module: `card_host_regs`

## Requirements
- R1: After reset, every stored register is zero. `irq`, `cmdStart`, `busRdValid` and `busErr` are low, and `bufAddr`, `cmdCode`, `cmdArg`, `blkLen` and `blkCount` read zero.
- R2: A read request (`busSel`=1, `busWrite`=0) returns its data on `busRdata` with `busRdValid` high in the next cycle. Offset 0x2C returns `cardPresent` in bit 0 and `cardReadOnly` in bit 1, with all other bits zero.
- R3: A read of offset 0x00 returns the status bits ANDed with the enable mask. Status bit 0 means end of command, bit 1 means end of data, bit 2 means card state change. All higher bits read zero.
- R4: A write to offset 0x00 clears each status bit whose written bit is 1 and leaves the others unchanged.
- R5: A write to offset 0x04 loads the low three bits as the enable mask and clears all status bits in the same cycle.
- R6: Any bit set on `engFlags` is ORed into status at the next clock edge. This holds even when a write to offset 0x00 or 0x04 clears that bit in the same cycle.
- R7: `irq` is high in a cycle exactly when status AND enable was nonzero in the previous cycle.
- R8: A write to offset 0x24 stores the written value plus one on `blkLen`. A write to offset 0x28 does the same on `blkCount`. The sum wraps modulo 2^32.
- R9: A write to offset 0x0C makes `cmdStart` high for exactly the following cycle. In that cycle `cmdCode` holds the written value and `cmdArg` holds the value last written to offset 0x10.
- R10: A read of an unmapped offset, an offset not aligned to a word, or a write-only offset (0x04, 0x08, 0x0C, 0x10, 0x24, 0x28) returns zero with `busErr` high for that one response cycle.
- R11: When `engRespValid` is high, `engResp` bits [32k+31:32k] load response word k. Word k reads back at offset 0x14+4k. Bus writes to the response offsets change nothing.
- R12: A write to offset 0x08 stores the value that appears on `bufAddr` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRdValid |
| busRdValid | output | 1 | Read response cycle |
| busErr | output | 1 | Read of an offset with nothing to read |
| cardPresent | input | 1 | Card inserted pin |
| cardReadOnly | input | 1 | Card write-protect pin |
| cmdStart | output | 1 | One-cycle command start pulse |
| cmdCode | output | 32 | Last written command value |
| cmdArg | output | 32 | Last written argument |
| bufAddr | output | 32 | Transfer buffer address |
| blkLen | output | 32 | Block length (written value plus one) |
| blkCount | output | 32 | Block count (written value plus one) |
| engRespValid | input | 1 | Response words valid from engine |
| engResp | input | 128 | Four response words, word 0 lowest |
| engFlags | input | 3 | Completion flags from engine, one-cycle pulses |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus makes at most one access per cycle, that `busWrite` is meaningful only while `busSel` is high, and that the card pins stay stable while a read of the state register is in flight. They also assume that `engFlags` carries only pulses the engine means to report, so the status checks compare against the flags sampled one cycle earlier. The stimulus drives every input on the falling edge, holds each access for exactly one cycle, and pulses engine flags for one cycle only. The one exception is the deliberate collision case, where a flag and a clearing write share a cycle.

// File: rtl/chr_pkg.sv
package chr_pkg;

  // Word indices of the register map (byte offset / 4)
  localparam int W_STATUS   = 0;
  localparam int W_ENABLE   = 1;
  localparam int W_BUF      = 2;
  localparam int W_CMD      = 3;
  localparam int W_ARG      = 4;
  localparam int W_RESP0    = 5;
  localparam int RESP_WORDS = 4;
  localparam int W_LEN      = W_RESP0 + RESP_WORDS;
  localparam int W_COUNT    = W_LEN + 1;
  localparam int W_CARD     = W_COUNT + 1;
  localparam int RIDX_W     = $clog2(RESP_WORDS);

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_RESP,
    SEL_CARD
  } rdsel_t;

  typedef struct packed {
    logic              wrStatus;
    logic              wrEnable;
    logic              wrBuf;
    logic              wrCmd;
    logic              wrArg;
    logic              wrLen;
    logic              wrCount;
    logic              rdEn;
    logic              rdBad;
    rdsel_t            rdSel;
    logic [RIDX_W-1:0] rdIdx;
  } strobe_t;

endpackage

// File: rtl/chr_ctrl.sv
module chr_ctrl
  import chr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           st
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  logic              doWr;
  logic              doRd;
  int                wi;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign doWr    = busSel && busWrite && aligned;
  assign doRd    = busSel && !busWrite;
  assign wi      = int'(wordIdx);

  always_comb begin
    st          = '0;
    st.rdSel    = SEL_NONE;
    st.wrStatus = doWr && (wi == W_STATUS);
    st.wrEnable = doWr && (wi == W_ENABLE);
    st.wrBuf    = doWr && (wi == W_BUF);
    st.wrCmd    = doWr && (wi == W_CMD);
    st.wrArg    = doWr && (wi == W_ARG);
    st.wrLen    = doWr && (wi == W_LEN);
    st.wrCount  = doWr && (wi == W_COUNT);
    st.rdEn     = doRd;
    if (doRd) begin
      if (!aligned) begin
        st.rdBad = 1'b1;
      end else if (wi == W_STATUS) begin
        st.rdSel = SEL_STATUS;
      end else if (wi >= W_RESP0 && wi < W_RESP0 + RESP_WORDS) begin
        st.rdSel = SEL_RESP;
        st.rdIdx = RIDX_W'(wi - W_RESP0);
      end else if (wi == W_CARD) begin
        st.rdSel = SEL_CARD;
      end else begin
        st.rdBad = 1'b1;
      end
    end
  end

endmodule

// File: rtl/chr_datapath.sv
module chr_datapath
  import chr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLAG_W = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    st,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic                       busRdValid,
  output logic                       busErr,
  input  logic                       cardPresent,
  input  logic                       cardReadOnly,
  output logic                       cmdStart,
  output logic [DATA_W-1:0]          cmdCode,
  output logic [DATA_W-1:0]          cmdArg,
  output logic [DATA_W-1:0]          bufAddr,
  output logic [DATA_W-1:0]          blkLen,
  output logic [DATA_W-1:0]          blkCount,
  input  logic                       engRespValid,
  input  logic [RESP_WORDS*DATA_W-1:0] engResp,
  input  logic [FLAG_W-1:0]          engFlags,
  output logic                       irq
);

  logic [FLAG_W-1:0] stsReg, stsNext, enReg;
  logic [DATA_W-1:0] respReg [RESP_WORDS];
  logic [DATA_W-1:0] rdMux;
  logic              irqReg;

  // Status: clear sources first, new flags last so they win
  always_comb begin
    stsNext = stsReg;
    if (st.wrEnable)      stsNext = '0;
    else if (st.wrStatus) stsNext = stsReg & ~busWdata[FLAG_W-1:0];
    stsNext = stsNext | engFlags;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsReg   <= '0;
      enReg    <= '0;
      irqReg   <= 1'b0;
      bufAddr  <= '0;
      cmdCode  <= '0;
      cmdArg   <= '0;
      blkLen   <= '0;
      blkCount <= '0;
      cmdStart <= 1'b0;
    end else begin
      stsReg   <= stsNext;
      irqReg   <= |(stsReg & enReg);
      cmdStart <= st.wrCmd;
      if (st.wrEnable) enReg    <= busWdata[FLAG_W-1:0];
      if (st.wrBuf)    bufAddr  <= busWdata;
      if (st.wrCmd)    cmdCode  <= busWdata;
      if (st.wrArg)    cmdArg   <= busWdata;
      if (st.wrLen)    blkLen   <= busWdata + DATA_W'(1);
      if (st.wrCount)  blkCount <= busWdata + DATA_W'(1);
    end
  end

  assign irq = irqReg;

  // Response words, one register per word
  for (genvar g = 0; g < RESP_WORDS; g++) begin : gResp
    always_ff @(posedge clk) begin
      if (!rstN)             respReg[g] <= '0;
      else if (engRespValid) respReg[g] <= engResp[g*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    case (st.rdSel)
      SEL_STATUS: rdMux = DATA_W'(stsReg & enReg);
      SEL_RESP:   rdMux = respReg[st.rdIdx];
      SEL_CARD:   rdMux = DATA_W'({cardReadOnly, cardPresent});
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata   <= '0;
      busRdValid <= 1'b0;
      busErr     <= 1'b0;
    end else begin
      busRdValid <= st.rdEn;
      busErr     <= st.rdEn && st.rdBad;
      if (st.rdEn) busRdata <= rdMux;
    end
  end

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrStatus && engFlags == '0) |=> ((stsReg & $past(busWdata[FLAG_W-1:0])) == '0));

  // R5
  enable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEnable |=> ((stsReg & ~$past(engFlags)) == '0));

  // R6
  flag_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engFlags != '0) |=> ((stsReg & $past(engFlags)) == $past(engFlags)));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |=> !irq);

  // R8
  len_plus_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrLen |=> (blkLen == $past(busWdata) + DATA_W'(1)));

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.wrCmd |=> (cmdStart && cmdCode == $past(busWdata)));

  // R9
  no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrCmd |=> !cmdStart);

  // R10
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdValid && busRdata == '0));

endmodule

// File: rtl/card_host_regs.sv
module card_host_regs
  import chr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [11:0]   busAddr,
  input  logic [31:0]   busWdata,
  output logic [31:0]   busRdata,
  output logic          busRdValid,
  output logic          busErr,
  input  logic          cardPresent,
  input  logic          cardReadOnly,
  output logic          cmdStart,
  output logic [31:0]   cmdCode,
  output logic [31:0]   cmdArg,
  output logic [31:0]   bufAddr,
  output logic [31:0]   blkLen,
  output logic [31:0]   blkCount,
  input  logic          engRespValid,
  input  logic [127:0]  engResp,
  input  logic [2:0]    engFlags,
  output logic          irq
);

  strobe_t st;

  chr_ctrl #(.ADDR_W(12)) uCtrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .st       (st)
  );

  chr_datapath #(.DATA_W(32), .FLAG_W(3)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .busRdValid   (busRdValid),
    .busErr       (busErr),
    .cardPresent  (cardPresent),
    .cardReadOnly (cardReadOnly),
    .cmdStart     (cmdStart),
    .cmdCode      (cmdCode),
    .cmdArg       (cmdArg),
    .bufAddr      (bufAddr),
    .blkLen       (blkLen),
    .blkCount     (blkCount),
    .engRespValid (engRespValid),
    .engResp      (engResp),
    .engFlags     (engFlags),
    .irq          (irq)
  );

endmodule

// File: tb/sim_card_host_regs.sv
module sim_card_host_regs;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0, busWrite = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         busRdValid, busErr;
  logic         cardPresent = 1'b1, cardReadOnly = 1'b0;
  logic         cmdStart;
  logic [31:0]  cmdCode, cmdArg, bufAddr, blkLen, blkCount;
  logic         engRespValid = 1'b0;
  logic [127:0] engResp = '0;
  logic [2:0]   engFlags = '0;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       req;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  card_host_regs u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] d, logic e, string req);
    expQ.push_back('{data: d, err: e, req: req});
    busSel = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic pulseFlags(logic [2:0] f);
    engFlags = f;
    @(negedge clk);
    engFlags = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected item per read response
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 actual=unexpected response expected=none");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.req, busRdata, e.data);
        chk({e.req, " err"}, {31'b0, busErr}, {31'b0, e.err});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 cmdStart", {31'b0, cmdStart}, 0);
    chk("R1 blkLen", blkLen, 0);
    chk("R1 blkCount", blkCount, 0);
    chk("R1 bufAddr", bufAddr, 0);
    rd(12'h000, 32'h0, 0, "R1 status");
    rd(12'h02C, 32'h1, 0, "R2 card present");

    // R5 enable all, R6 flag in, R7 irq one cycle later
    wr(12'h004, 32'h7);
    pulseFlags(3'b001);
    chk("R7 irq not yet", {31'b0, irq}, 0);
    idle(1);
    chk("R7 irq", {31'b0, irq}, 1);
    rd(12'h000, 32'h1, 0, "R6 status");
    pulseFlags(3'b010);
    rd(12'h000, 32'h3, 0, "R6 status or");
    // R4 write-one-to-clear
    wr(12'h000, 32'h2);
    rd(12'h000, 32'h1, 0, "R4 w1c");
    // R6 collision: new flag beats clear
    engFlags = 3'b001;
    wr(12'h000, 32'h1);
    engFlags = '0;
    rd(12'h000, 32'h1, 0, "R6 collision");
    // R3 masking
    wr(12'h004, 32'h2);
    pulseFlags(3'b011);
    rd(12'h000, 32'h2, 0, "R3 masked");
    chk("R7 irq masked bit", {31'b0, irq}, 1);
    // R5 enable write clears status
    wr(12'h004, 32'h1);
    idle(2);
    chk("R5 irq after clear", {31'b0, irq}, 0);
    rd(12'h000, 32'h0, 0, "R5 cleared");
    pulseFlags(3'b010);
    idle(2);
    chk("R7 disabled flag", {31'b0, irq}, 0);
    rd(12'h000, 32'h0, 0, "R3 disabled bit");

    // R8 plus one
    wr(12'h024, 32'd511);
    chk("R8 blkLen", blkLen, 32'd512);
    wr(12'h028, 32'd0);
    chk("R8 blkCount", blkCount, 32'd1);
    wr(12'h028, 32'hFFFF_FFFF);
    chk("R8 wrap", blkCount, 32'd0);

    // R9 command start
    wr(12'h010, 32'hDEAD_BEEF);
    wr(12'h00C, 32'h19);
    chk("R9 start", {31'b0, cmdStart}, 1);
    chk("R9 code", cmdCode, 32'h19);
    chk("R9 arg", cmdArg, 32'hDEAD_BEEF);
    idle(1);
    chk("R9 single pulse", {31'b0, cmdStart}, 0);

    // R12 buffer address
    wr(12'h008, 32'h8000_1000);
    chk("R12 bufAddr", bufAddr, 32'h8000_1000);

    // R11 responses
    engResp = {32'h4444_0003, 32'h3333_0002, 32'h2222_0001, 32'h1111_0000};
    engRespValid = 1;
    @(negedge clk);
    engRespValid = 0;
    rd(12'h014, 32'h1111_0000, 0, "R11 word0");
    rd(12'h018, 32'h2222_0001, 0, "R11 word1");
    rd(12'h01C, 32'h3333_0002, 0, "R11 word2");
    rd(12'h020, 32'h4444_0003, 0, "R11 word3");
    wr(12'h014, 32'h0);
    rd(12'h014, 32'h1111_0000, 0, "R11 write ignored");

    // R2 card pins
    cardReadOnly = 1;
    rd(12'h02C, 32'h3, 0, "R2 read-only");
    cardPresent = 0;
    rd(12'h02C, 32'h2, 0, "R2 removed");

    // R10 bad reads
    rd(12'h030, 32'h0, 1, "R10 unmapped");
    rd(12'h004, 32'h0, 1, "R10 write-only");
    rd(12'h016, 32'h0, 1, "R10 unaligned");
    rd(12'hFFC, 32'h0, 1, "R10 top of window");
    idle(2);
    chk("R2 all responses seen", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule